// File: doc/BRIEF.md
# Way-Predicting Two-Way Cache Lookup

This block is the lookup front end of a small two-way set-associative cache. Every set carries one prediction bit that names the way expected to hold the next access to that set. When a request is accepted, the data multiplexer is already steered by that bit, and a single tag comparison against the predicted way runs in the same cycle. A correct guess returns data one cycle after acceptance. A wrong guess sends the lookup into a second cycle, where the same comparator checks the other way. A match there is a slow hit, and the prediction bit is retrained to the way that hit.

When neither way matches, the block reports a miss and holds the request side stalled until a refill line arrives on the fill port. The line is written at the address of the missed request. The predictor then points at the way that was refilled. Tag, valid and data storage are internal register arrays. Fetching from memory, writes and coherence are left to the surrounding logic.

Top module: `wp_cache_lookup`

## Requirements
- R1: After reset, `req_ready` is high, no result pulse is asserted, every line is invalid (the first access to any address is a miss) and every set predicts way 0.
- R2: An address is split into an index (its low log2(SETS) bits) and a tag (the remaining upper bits). A request accepted while the predicted way of its set is valid and holds its tag raises `rsp_hit` for exactly the cycle after acceptance, with `rsp_data` equal to that line's data.
- R3: When the predicted way does not match, no pulse appears in the cycle after acceptance. If the other way is valid and matches, `rsp_slow_hit` pulses in the second cycle after acceptance, with that way's data on `rsp_data`.
- R4: After a slow hit, the set's prediction points at the way that hit, so the next access to the same address is a one-cycle hit.
- R5: When neither way matches, `rsp_miss` pulses in the second cycle after acceptance and the block then waits for a refill line.
- R6: `req_ready` is low during the second-cycle check and while a refill is awaited. A request offered in those cycles is not taken and changes no state.
- R7: A refill (`fill_valid` while a refill is awaited) writes `fill_data` with the missed tag into the missed set. The way is chosen in this order: way 0 if it is invalid, else way 1 if it is invalid, else the way the set does not predict. The prediction then names the filled way, and `req_ready` is high again in the next cycle.
- R8: `fill_valid` is ignored whenever no refill is awaited. Stored lines, predictions and outputs are unchanged.
- R9: The three result pulses are mutually exclusive and each lasts one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can take a request this cycle |
| req_addr | input | ADDR_W | Request address: tag in upper bits, set index in low bits |
| rsp_data | output | DATA_W | Line data, meaningful while a hit pulse is high |
| rsp_hit | output | 1 | One-cycle pulse: hit in the predicted way |
| rsp_slow_hit | output | 1 | One-cycle pulse: hit in the other way, one cycle later |
| rsp_miss | output | 1 | One-cycle pulse: no way matched |
| fill_valid | input | 1 | Refill line present |
| fill_data | input | DATA_W | Refill line data |

## Verification
A directed run in one set walks through every outcome. It starts with a cold miss into an empty set, then fills an invalid way 0 and then an invalid way 1. A wrong guess with a match in the other way follows, then the retrained access that must hit at once. A miss with both ways full shows which line gets evicted. Each step is told apart by which pulse appears and in which cycle. A stray refill strobe between accesses must leave the following hit and its data unchanged. A random run then mixes accesses over a few sets and tags, fill strobes at random delays (some arriving during the second-cycle check) and requests held up while the block stalls. Every cycle is compared against a behavioural model of sets, predictions and state.

// File: rtl/wp_cache_pkg.sv
// Shared types for the way-predicting lookup.
// Assumes a two-way organisation, so one bit names a way.
package wp_cache_pkg;

    localparam int NUM_WAYS = 2;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_PROBE2 = 2'd1,
        ST_REFILL = 2'd2
    } wp_state_t;

endpackage

// File: rtl/wp_way_store.sv
// Tag, valid and data arrays for both ways, one register array per way.
// Reads are combinational at rd_idx; one line is written per cycle.
// Assumes SETS is a power of two. Only the valid bits are reset.
module wp_way_store #(
    parameter int SETS   = 8,
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                                           clk,
    input  logic                                           rst_n,
    input  logic [IDX_W-1:0]                               rd_idx,
    output logic [wp_cache_pkg::NUM_WAYS-1:0]              rd_valid,
    output logic [wp_cache_pkg::NUM_WAYS-1:0][TAG_W-1:0]   rd_tag,
    output logic [wp_cache_pkg::NUM_WAYS-1:0][DATA_W-1:0]  rd_data,
    input  logic                                           wr_en,
    input  logic                                           wr_way,
    input  logic [IDX_W-1:0]                               wr_idx,
    input  logic [TAG_W-1:0]                               wr_tag,
    input  logic [DATA_W-1:0]                              wr_data
);

    for (genvar w = 0; w < wp_cache_pkg::NUM_WAYS; w++) begin : g_way
        logic [SETS-1:0]   valid_q;
        logic [TAG_W-1:0]  tag_q  [SETS];
        logic [DATA_W-1:0] data_q [SETS];
        logic              way_we;

        assign way_we = wr_en && (wr_way == 1'(w));

        // Valid bits: cleared by reset, set when a line is written.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
            end else if (way_we) begin
                valid_q[wr_idx] <= 1'b1;
            end
        end

        // Tag and data storage: written together on a refill.
        always_ff @(posedge clk) begin
            if (way_we) begin
                tag_q[wr_idx]  <= wr_tag;
                data_q[wr_idx] <= wr_data;
            end
        end

        assign rd_valid[w] = valid_q[rd_idx];
        assign rd_tag[w]   = tag_q[rd_idx];
        assign rd_data[w]  = data_q[rd_idx];
    end

endmodule

// File: rtl/wp_way_predictor.sv
// One prediction bit per set, naming the way expected to hit next.
// Reset points every set at way 0. One update per cycle.
module wp_way_predictor #(
    parameter int SETS = 8,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             pred_way,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  logic             upd_way
);

    logic [SETS-1:0] pred_q;

    // Prediction bits: zero after reset, retrained on slow hit or refill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pred_q <= '0;
        end else if (upd_en) begin
            pred_q[upd_idx] <= upd_way;
        end
    end

    assign pred_way = pred_q[rd_idx];

endmodule

// File: rtl/wp_probe.sv
// The single tag comparator and the way data multiplexer.
// Both are steered by way_sel, so data selection does not wait on the compare.
module wp_probe #(
    parameter int TAG_W  = 9,
    parameter int DATA_W = 32
) (
    input  logic                                           way_sel,
    input  logic [TAG_W-1:0]                               req_tag,
    input  logic [wp_cache_pkg::NUM_WAYS-1:0]              rd_valid,
    input  logic [wp_cache_pkg::NUM_WAYS-1:0][TAG_W-1:0]   rd_tag,
    input  logic [wp_cache_pkg::NUM_WAYS-1:0][DATA_W-1:0]  rd_data,
    output logic                                           match,
    output logic [DATA_W-1:0]                              sel_data
);

    // One comparison per cycle, against the selected way only.
    always_comb begin
        match    = rd_valid[way_sel] && (rd_tag[way_sel] == req_tag);
        sel_data = rd_data[way_sel];
    end

endmodule

// File: rtl/wp_lookup_ctrl.sv
// Lookup sequencer: idle/accept, second-way check, wait for refill.
// Registers the three result pulses. Assumes probe_hit reflects the way
// chosen for the current state in the same cycle.
module wp_lookup_ctrl
    import wp_cache_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      fill_valid,
    input  logic      probe_hit,
    output wp_state_t state_q,
    output logic      req_ready,
    output logic      accept,
    output logic      retrain,
    output logic      fill_take,
    output logic      fast_q,
    output logic      slow_q,
    output logic      miss_q
);

    wp_state_t state_d;

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign retrain   = (state_q == ST_PROBE2) && probe_hit;
    assign fill_take = (state_q == ST_REFILL) && fill_valid;

    // Next-state selection for the three-phase lookup.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept && !probe_hit) state_d = ST_PROBE2;
            ST_PROBE2: state_d = probe_hit ? ST_IDLE : ST_REFILL;
            ST_REFILL: if (fill_valid) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result pulses, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fast_q <= 1'b0;
            slow_q <= 1'b0;
            miss_q <= 1'b0;
        end else begin
            fast_q <= accept && probe_hit;
            slow_q <= retrain;
            miss_q <= (state_q == ST_PROBE2) && !probe_hit;
        end
    end

endmodule

// File: rtl/wp_cache_lookup.sv
// Way-predicting two-way cache lookup, top level.
// Cycle after accept: hit in the predicted way, or a second-cycle check of
// the other way; a miss then waits for a refill line on the fill port.
// Assumes the refill for a miss is the only fill that matters; other
// fill strobes are dropped.
module wp_cache_lookup
    import wp_cache_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int SETS   = 8,
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              rsp_hit,
    output logic              rsp_slow_hit,
    output logic              rsp_miss,
    input  logic              fill_valid,
    input  logic [DATA_W-1:0] fill_data
);

    wp_state_t                          state_q;
    logic                               accept;
    logic                               retrain;
    logic                               fill_take;
    logic                               probe_hit;
    logic [ADDR_W-1:0]                  cap_addr_q;
    logic [ADDR_W-1:0]                  cur_addr;
    logic [IDX_W-1:0]                   cur_idx;
    logic [TAG_W-1:0]                   cur_tag;
    logic                               pred_way;
    logic                               way_sel;
    logic                               victim_way;
    logic                               upd_way;
    logic [NUM_WAYS-1:0]                rd_valid;
    logic [NUM_WAYS-1:0][TAG_W-1:0]     rd_tag;
    logic [NUM_WAYS-1:0][DATA_W-1:0]    rd_data;
    logic [DATA_W-1:0]                  sel_data;
    logic [DATA_W-1:0]                  rsp_data_q;

    // Address source: live request when idle, captured address otherwise.
    always_comb begin
        cur_addr = (state_q == ST_IDLE) ? req_addr : cap_addr_q;
        cur_idx  = cur_addr[IDX_W-1:0];
        cur_tag  = cur_addr[ADDR_W-1:IDX_W];
    end

    // Way steering: predicted way first, the other way in the second cycle.
    always_comb begin
        way_sel = (state_q == ST_PROBE2) ? ~pred_way : pred_way;
    end

    // Refill victim: invalid way 0, then invalid way 1, then the unpredicted way.
    always_comb begin
        if (!rd_valid[0])      victim_way = 1'b0;
        else if (!rd_valid[1]) victim_way = 1'b1;
        else                   victim_way = ~pred_way;
        upd_way = fill_take ? victim_way : way_sel;
    end

    // Capture the request address on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cap_addr_q <= '0;
        else if (accept) cap_addr_q <= req_addr;
    end

    // Return data register, loaded on either kind of hit.
    always_ff @(posedge clk) begin
        if (!rst_n)                            rsp_data_q <= '0;
        else if ((accept && probe_hit) || retrain) rsp_data_q <= sel_data;
    end

    wp_lookup_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .fill_valid (fill_valid),
        .probe_hit  (probe_hit),
        .state_q    (state_q),
        .req_ready  (req_ready),
        .accept     (accept),
        .retrain    (retrain),
        .fill_take  (fill_take),
        .fast_q     (rsp_hit),
        .slow_q     (rsp_slow_hit),
        .miss_q     (rsp_miss)
    );

    wp_way_store #(
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .wr_en    (fill_take),
        .wr_way   (victim_way),
        .wr_idx   (cur_idx),
        .wr_tag   (cur_tag),
        .wr_data  (fill_data)
    );

    wp_way_predictor #(
        .SETS (SETS)
    ) u_pred (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (cur_idx),
        .pred_way (pred_way),
        .upd_en   (retrain || fill_take),
        .upd_idx  (cur_idx),
        .upd_way  (upd_way)
    );

    wp_probe #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_probe (
        .way_sel  (way_sel),
        .req_tag  (cur_tag),
        .rd_valid (rd_valid),
        .rd_tag   (rd_tag),
        .rd_data  (rd_data),
        .match    (probe_hit),
        .sel_data (sel_data)
    );

    assign rsp_data = rsp_data_q;

endmodule

// File: rtl/wp_cache_lookup_chk.sv
// Protocol checker for wp_cache_lookup, attached by bind.
// Relates the request handshake, fill strobe, result pulses and state.
module wp_cache_lookup_chk
    import wp_cache_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic       fill_valid,
    input logic       rsp_hit,
    input logic       rsp_slow_hit,
    input logic       rsp_miss,
    input logic [1:0] state_q
);

    assert_one_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rsp_hit, rsp_slow_hit, rsp_miss}));

    assert_fast_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> $past(req_valid && req_ready));

    assert_mispredict_stalls_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_hit || !req_ready));

    assert_second_look_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_slow_hit || rsp_miss) |-> $past(!req_ready));

    assert_slow_hit_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_slow_hit |-> req_ready);

    assert_miss_waits_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (!req_ready && state_q == ST_REFILL));

    assert_fill_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_REFILL && fill_valid) |=> req_ready);

    assert_idle_fill_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && !req_valid) |=> (req_ready && !rsp_hit && !rsp_slow_hit && !rsp_miss));

endmodule

bind wp_cache_lookup wp_cache_lookup_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .fill_valid   (fill_valid),
    .rsp_hit      (rsp_hit),
    .rsp_slow_hit (rsp_slow_hit),
    .rsp_miss     (rsp_miss),
    .state_q      (state_q)
);

// File: tb/wp_cache_lookup_test.sv
module wp_cache_lookup_test;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 12;
    localparam int DATA_W     = 32;
    localparam int SETS       = 8;
    localparam int IDX_W      = $clog2(SETS);
    localparam int TAG_W      = ADDR_W - IDX_W;
    localparam int WATCHDOG   = 100000;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              req_valid;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr;
    logic [DATA_W-1:0] rsp_data;
    logic              rsp_hit;
    logic              rsp_slow_hit;
    logic              rsp_miss;
    logic              fill_valid;
    logic [DATA_W-1:0] fill_data;

    int n_checks = 0;
    int n_fails  = 0;
    bit chk_on   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    wp_cache_lookup #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) uut (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_ready (req_ready),
        .req_addr (req_addr), .rsp_data (rsp_data), .rsp_hit (rsp_hit),
        .rsp_slow_hit (rsp_slow_hit), .rsp_miss (rsp_miss),
        .fill_valid (fill_valid), .fill_data (fill_data)
    );

    // Behavioural reference: 0 idle, 1 second look, 2 waiting for refill.
    int                m_state;
    bit                m_valid [2][SETS];
    logic [TAG_W-1:0]  m_tag   [2][SETS];
    logic [DATA_W-1:0] m_data  [2][SETS];
    int                m_pred  [SETS];
    logic [ADDR_W-1:0] m_addr;
    bit                e_fast, e_slow, e_miss, e_ready;
    logic [DATA_W-1:0] e_data;

    always @(posedge clk) begin : model
        int ix, p, o, w;
        logic [TAG_W-1:0] t;
        if (!rst_n) begin
            m_state = 0;
            e_fast = 0; e_slow = 0; e_miss = 0;
            for (int s = 0; s < SETS; s++) begin
                m_valid[0][s] = 0; m_valid[1][s] = 0; m_pred[s] = 0;
            end
        end else begin
            e_fast = 0; e_slow = 0; e_miss = 0;
            if (m_state == 0) begin
                if (req_valid) begin
                    ix = int'(req_addr[IDX_W-1:0]);
                    t  = req_addr[ADDR_W-1:IDX_W];
                    p  = m_pred[ix];
                    if (m_valid[p][ix] && m_tag[p][ix] == t) begin
                        e_fast = 1; e_data = m_data[p][ix];
                    end else begin
                        m_state = 1; m_addr = req_addr;
                    end
                end
            end else if (m_state == 1) begin
                ix = int'(m_addr[IDX_W-1:0]);
                t  = m_addr[ADDR_W-1:IDX_W];
                o  = 1 - m_pred[ix];
                if (m_valid[o][ix] && m_tag[o][ix] == t) begin
                    e_slow = 1; e_data = m_data[o][ix]; m_pred[ix] = o; m_state = 0;
                end else begin
                    e_miss = 1; m_state = 2;
                end
            end else begin
                if (fill_valid) begin
                    ix = int'(m_addr[IDX_W-1:0]);
                    if (!m_valid[0][ix])      w = 0;
                    else if (!m_valid[1][ix]) w = 1;
                    else                      w = 1 - m_pred[ix];
                    m_valid[w][ix] = 1;
                    m_tag[w][ix]   = m_addr[ADDR_W-1:IDX_W];
                    m_data[w][ix]  = fill_data;
                    m_pred[ix]     = w;
                    m_state        = 0;
                end
            end
        end
        e_ready = (m_state == 0);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (chk_on) begin
            check(req_ready == e_ready, "R6", "req_ready", 64'(req_ready), 64'(e_ready));
            check(rsp_hit == e_fast, "R2", "rsp_hit", 64'(rsp_hit), 64'(e_fast));
            check(rsp_slow_hit == e_slow, "R3", "rsp_slow_hit", 64'(rsp_slow_hit), 64'(e_slow));
            check(rsp_miss == e_miss, "R5", "rsp_miss", 64'(rsp_miss), 64'(e_miss));
            check($countones({rsp_hit, rsp_slow_hit, rsp_miss}) <= 1, "R9", "pulse count",
                  64'($countones({rsp_hit, rsp_slow_hit, rsp_miss})), 64'd1);
            if (e_fast || e_slow)
                check(rsp_data == e_data, "R2/R3", "rsp_data", 64'(rsp_data), 64'(e_data));
        end
    end

    function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
        return {TAG_W'(tag), IDX_W'(idx)};
    endfunction

    // One access; want: 1 fast hit, 2 slow hit, 4 miss, 0 no kind check.
    task automatic access(input logic [ADDR_W-1:0] a, input int want, input string req);
        int seen = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a;
        @(negedge clk);
        seen |= {rsp_miss, rsp_slow_hit, rsp_hit};
        while (m_state != 0) begin
            req_valid  = 1'b1;
            req_addr   = ~a;
            fill_data  = $urandom;
            fill_valid = ($urandom % 3 == 0);
            @(negedge clk);
            fill_valid = 1'b0;
            seen |= {rsp_miss, rsp_slow_hit, rsp_hit};
        end
        req_valid = 1'b0;
        if (want != 0) check(seen == want, req, "result kind", 64'(seen), 64'(want));
    endtask

    task automatic stray_fill();
        @(negedge clk);
        fill_valid = 1'b1; fill_data = $urandom;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", WATCHDOG);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : stimulus
        rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; fill_valid = 1'b0; fill_data = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_on = 1'b1;
        // R1: reset state at the ports
        check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        check({rsp_hit, rsp_slow_hit, rsp_miss} == 3'b000, "R1", "pulses after reset",
              64'({rsp_hit, rsp_slow_hit, rsp_miss}), 64'd0);

        access(mk(5, 3), 4, "R1");   // cold miss, fill into way 0
        access(mk(5, 3), 1, "R7");   // filled line hits in predicted way 0
        access(mk(9, 3), 4, "R5");   // way 1 invalid: miss, fill into way 1
        access(mk(9, 3), 1, "R7");   // prediction moved to way 1
        access(mk(5, 3), 2, "R3");   // wrong guess, other way matches
        access(mk(5, 3), 1, "R4");   // retrained prediction
        access(mk(2, 3), 4, "R5");   // both valid: evicts the unpredicted way 1
        access(mk(5, 3), 2, "R7");   // way 0 kept, now reached as slow hit
        access(mk(9, 3), 4, "R7");   // evicted line misses again
        stray_fill();
        access(mk(9, 3), 1, "R8");   // stray fill changed nothing
        stray_fill();
        access(mk(1, 5), 4, "R1");   // untouched set still empty

        for (int i = 0; i < 300; i++) begin
            if ($urandom % 8 == 0) stray_fill();
            access(mk(int'($urandom % 6), int'($urandom % 4)), 0, "R6");
        end

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule